// File: doc/BRIEF.md
# Clearable Static Memory with Split Data Buses

This block is a synchronous 1024-word by 4-bit storage array. Data enters on its own 4-bit input bus and leaves on a separate 4-bit output bus. Four active-low controls govern it: select, write, output enable and clear. Internally the bits sit in a 64-row by 64-column grid. The low six address bits pick a row and the upper four pick one of sixteen 4-bit groups in that row.

Accesses are sampled on the rising clock edge. A read returns its word on the cycle after it is issued, together with a valid flag. The valid flag stands in for an output that would otherwise float: whenever no read is in progress, the flag is low and the bus is held at zero. Memory access is a plain cycle-by-cycle operation, so the controls are level pins and the block has no back-pressure.

A clear runs only on a selected device. It wipes the array in two cycles: the lower 32 rows on the edge that samples the request, then the upper 32 rows on the next edge. A busy flag is high during that second cycle. This lets a clear line shared by several devices act only on the selected ones.

Top module: `clr_sram`

## Requirements
- R1: With `cs_n`=0, `we_n`=0 and `clr_n`=1, and no clear in progress, the edge stores `din` at `addr`.
- R2: With `cs_n`=0, `oe_n`=0, `we_n`=1 and `clr_n`=1 sampled on an edge, the cycle after that edge shows `dout_vld`=1 and `dout` equal to the addressed word.
- R3: If an edge samples `cs_n`=1, `oe_n`=1, `we_n`=0 or `clr_n`=0, then `dout_vld`=0 in the following cycle. Whenever `dout_vld` is 0, `dout` is 0.
- R4: `addr[5:0]` selects the row and `addr[9:6]` selects the 4-bit group. Addresses that differ in any single bit hold independent words.
- R5: `clr_n`=0 while `cs_n`=1 clears nothing. Stored words are unchanged.
- R6: An edge sampling `cs_n`=0 and `clr_n`=0 zeroes rows 0–31 on that edge and rows 32–63 on the next edge. `clr_busy` is 1 for exactly that one intermediate cycle, even if `clr_n` returns high. Afterwards every address reads 0.
- R7: If an edge samples `clr_n`=0 and `we_n`=0 together with `cs_n`=0, the clear wins and the write is not performed.
- R8: While `clr_busy`=1, a write is ignored and a read returns `dout`=0 with `dout_vld`=1.
- R9: While `rst_n`=0, `dout_vld`, `dout` and `clr_busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset of the control state, active low |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| clr_n | input | 1 | Whole-array clear request, active low, gated by select |
| addr | input | 10 | Word address: bits 5:0 row, bits 9:6 group |
| din | input | 4 | Write data |
| dout | output | 4 | Read data, zero when not valid |
| dout_vld | output | 1 | Read data valid; low stands for a floating output |
| clr_busy | output | 1 | Second clear phase in progress |

## Verification
Words are written to the all-zero address, the all-ones address, and to addresses that each have a single row bit or a single group bit set. Reading them back shows a swapped or merged address split, because each word is distinct. Each of the four conditions that gate the output is applied on its own, so a missing term in the valid logic shows up. A clear with select high, a clear combined with a write, and a write or read in the busy cycle are each tried separately. A full sweep after a one-cycle clear pulse shows whether the upper half was zeroed by the second phase.

// File: rtl/clr_sram_pkg.sv
package clr_sram_pkg;
  parameter int DEF_ROW_BITS = 6;
  parameter int DEF_COL_BITS = 4;
  parameter int DEF_WORD_W   = 4;

  typedef struct packed {
    logic clr;
    logic wr;
    logic rd;
  } mem_cmd_t;
endpackage

// File: rtl/clr_sram_ctrl.sv
module clr_sram_ctrl
  import clr_sram_pkg::*;
(
  input  logic     cs_n,
  input  logic     we_n,
  input  logic     oe_n,
  input  logic     clr_n,
  output mem_cmd_t cmd
);
  always_comb begin
    cmd     = '0;
    cmd.clr = !cs_n && !clr_n;
    cmd.wr  = !cs_n && !we_n && clr_n;
    cmd.rd  = !cs_n && !oe_n && we_n && clr_n;
  end
endmodule

// File: rtl/clr_sram_clrseq.sv
module clr_sram_clrseq (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_req,
  output logic lo_clr,
  output logic hi_clr,
  output logic busy
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= clr_req;
  end

  assign lo_clr = clr_req;
  assign hi_clr = busy_q;
  assign busy   = busy_q;
endmodule

// File: rtl/clr_sram_array.sv
module clr_sram_array #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int WORD_W   = 4
) (
  input  logic                clk,
  input  logic                wr_en,
  input  logic [ROW_BITS-1:0] row,
  input  logic [COL_BITS-1:0] col,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                lo_clr,
  input  logic                hi_clr,
  output logic [WORD_W-1:0]   rdata
);
  localparam int ROWS  = 1 << ROW_BITS;
  localparam int HALF  = ROWS / 2;
  localparam int ROW_W = (1 << COL_BITS) * WORD_W;

  logic [ROW_W-1:0] row_q [ROWS];

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    localparam bit IN_LO = (r < HALF);
    logic clr_this;
    assign clr_this = IN_LO ? lo_clr : hi_clr;

    always_ff @(posedge clk) begin
      if (clr_this)
        row_q[r] <= '0;
      else if (wr_en && (row == ROW_BITS'(r)))
        row_q[r][col*WORD_W +: WORD_W] <= wdata;
    end
  end

  assign rdata = row_q[row][col*WORD_W +: WORD_W];
endmodule

// File: rtl/clr_sram.sv
module clr_sram
  import clr_sram_pkg::*;
#(
  parameter int ROW_BITS = DEF_ROW_BITS,
  parameter int COL_BITS = DEF_COL_BITS,
  parameter int WORD_W   = DEF_WORD_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cs_n,
  input  logic                         we_n,
  input  logic                         oe_n,
  input  logic                         clr_n,
  input  logic [ROW_BITS+COL_BITS-1:0] addr,
  input  logic [WORD_W-1:0]            din,
  output logic [WORD_W-1:0]            dout,
  output logic                         dout_vld,
  output logic                         clr_busy
);
  localparam int ADDR_W = ROW_BITS + COL_BITS;

  mem_cmd_t            cmd;
  logic                lo_clr, hi_clr, busy;
  logic [WORD_W-1:0]   rdata;
  logic [WORD_W-1:0]   dout_q;
  logic                vld_q;

  clr_sram_ctrl u_ctrl (
    .cs_n (cs_n),
    .we_n (we_n),
    .oe_n (oe_n),
    .clr_n(clr_n),
    .cmd  (cmd)
  );

  clr_sram_clrseq u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_req(cmd.clr),
    .lo_clr (lo_clr),
    .hi_clr (hi_clr),
    .busy   (busy)
  );

  clr_sram_array #(
    .ROW_BITS(ROW_BITS),
    .COL_BITS(COL_BITS),
    .WORD_W  (WORD_W)
  ) u_array (
    .clk   (clk),
    .wr_en (cmd.wr && !busy),
    .row   (addr[ROW_BITS-1:0]),
    .col   (addr[ADDR_W-1:ROW_BITS]),
    .wdata (din),
    .lo_clr(lo_clr),
    .hi_clr(hi_clr),
    .rdata (rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q  <= cmd.rd;
      dout_q <= (cmd.rd && !busy) ? rdata : '0;
    end
  end

  assign dout     = dout_q;
  assign dout_vld = vld_q;
  assign clr_busy = busy;
endmodule

// File: rtl/clr_sram_chk.sv
module clr_sram_chk #(
  parameter int ROW_BITS = 6,
  parameter int COL_BITS = 4,
  parameter int WORD_W   = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         cs_n,
  input logic                         we_n,
  input logic                         oe_n,
  input logic                         clr_n,
  input logic [ROW_BITS+COL_BITS-1:0] addr,
  input logic [WORD_W-1:0]            din,
  input logic [WORD_W-1:0]            dout,
  input logic                         dout_vld,
  input logic                         clr_busy
);
  a_r2_read_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !oe_n && we_n && clr_n) |=> dout_vld);

  a_r3_gated_off: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || oe_n || !we_n || !clr_n) |=> !dout_vld);

  a_r3_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_vld |-> (dout == '0));

  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && !clr_n) |=> clr_busy);

  a_r6_busy_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    clr_busy |-> $past(!cs_n && !clr_n));

  a_r8_busy_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_busy && !cs_n && !oe_n && we_n && clr_n) |=> (dout == '0));
endmodule

bind clr_sram clr_sram_chk #(
  .ROW_BITS(ROW_BITS),
  .COL_BITS(COL_BITS),
  .WORD_W  (WORD_W)
) u_chk (.*);

// File: tb/clr_sram_bench.sv
module clr_sram_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, clr_n = 1'b1;
  logic [9:0] addr = '0;
  logic [3:0] din = '0;
  logic [3:0] dout;
  logic       dout_vld, clr_busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clr_sram u_clr_sram (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n),
    .clr_n(clr_n), .addr(addr), .din(din), .dout(dout),
    .dout_vld(dout_vld), .clr_busy(clr_busy)
  );

  typedef struct packed {
    logic       cs_n, we_n, oe_n, clr_n;
    logic [9:0] addr;
    logic [3:0] din;
    logic       exp_vld;
    logic [3:0] exp_dout;
    logic [3:0] req;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0,1'b0,1'b1,1'b1,10'h000,4'h5,1'b0,4'h0,4'd1}, // R1 write
    '{1'b0,1'b0,1'b1,1'b1,10'h3FF,4'hA,1'b0,4'h0,4'd1}, // R1
    '{1'b0,1'b0,1'b1,1'b1,10'h001,4'h3,1'b0,4'h0,4'd4}, // R4 row bit
    '{1'b0,1'b0,1'b1,1'b1,10'h040,4'hC,1'b0,4'h0,4'd4}, // R4 group bit
    '{1'b0,1'b0,1'b1,1'b1,10'h020,4'h6,1'b0,4'h0,4'd4}, // R4 top row bit
    '{1'b0,1'b0,1'b1,1'b1,10'h200,4'h9,1'b0,4'h0,4'd4}, // R4 top group bit
    '{1'b0,1'b1,1'b0,1'b1,10'h000,4'h0,1'b1,4'h5,4'd2}, // R2 read
    '{1'b0,1'b1,1'b0,1'b1,10'h3FF,4'h0,1'b1,4'hA,4'd2}, // R2
    '{1'b0,1'b1,1'b0,1'b1,10'h001,4'h0,1'b1,4'h3,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b1,10'h040,4'h0,1'b1,4'hC,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b1,10'h020,4'h0,1'b1,4'h6,4'd4}, // R4
    '{1'b0,1'b1,1'b0,1'b1,10'h200,4'h0,1'b1,4'h9,4'd4}, // R4
    '{1'b0,1'b1,1'b1,1'b1,10'h000,4'h0,1'b0,4'h0,4'd3}, // R3 oe high
    '{1'b1,1'b1,1'b0,1'b1,10'h000,4'h0,1'b0,4'h0,4'd3}, // R3 deselected
    '{1'b0,1'b0,1'b0,1'b1,10'h100,4'hF,1'b0,4'h0,4'd3}, // R3 write with oe low
    '{1'b0,1'b1,1'b0,1'b1,10'h100,4'h0,1'b1,4'hF,4'd1}, // R1 readback
    '{1'b1,1'b1,1'b0,1'b0,10'h000,4'h0,1'b0,4'h0,4'd5}, // R5 clear deselected
    '{1'b0,1'b1,1'b0,1'b1,10'h3FF,4'h0,1'b1,4'hA,4'd5}  // R5 data kept
  };

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual vld/data=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic w, input logic o, input logic r,
                      input logic [9:0] a, input logic [3:0] d);
    cs_n = c; we_n = w; oe_n = o; clr_n = r; addr = a; din = d;
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    step(1'b1, 1'b1, 1'b1, 1'b1, 10'h000, 4'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R9: quiet outputs while held in reset
    check("R9 reset", {dout_vld, dout}, 5'h00);
    checks++;
    if (clr_busy !== 1'b0) begin
      errors++;
      $display("FAIL R9 busy actual=%b expected=0", clr_busy);
    end
    rst_n = 1'b1;
    idle();

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].cs_n, VEC[i].we_n, VEC[i].oe_n, VEC[i].clr_n, VEC[i].addr, VEC[i].din);
      check($sformatf("R%0d vec %0d", VEC[i].req, i), {dout_vld, dout},
            {VEC[i].exp_vld, VEC[i].exp_dout});
    end

    // R3: clear request also gates the output
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'h0);
    check("R3 clear gates output", {dout_vld, dout}, 5'h00);
    // R6: busy for exactly one cycle
    checks++;
    if (clr_busy !== 1'b1) begin
      errors++;
      $display("FAIL R6 busy actual=%b expected=1", clr_busy);
    end
    // R8: read during busy returns zero even for an upper-half row
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'h3FF, 4'h0);
    check("R8 busy read", {dout_vld, dout}, 5'h10);
    checks++;
    if (clr_busy !== 1'b0) begin
      errors++;
      $display("FAIL R6 busy end actual=%b expected=0", clr_busy);
    end

    // R1/R4: refill, then a one-cycle clear pulse and full sweep (R6)
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h3FF, 4'h7);
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h020, 4'h2);
    step(1'b0, 1'b1, 1'b0, 1'b0, 10'h000, 4'h0);
    // R8: write into a lower row during busy is dropped
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h001, 4'hE);
    idle();
    for (int a = 0; a < 1024; a++) begin
      step(1'b0, 1'b1, 1'b0, 1'b1, 10'(a), 4'h0);
      check($sformatf("R6 sweep addr %0h", a), {dout_vld, dout}, 5'h10);
    end

    // R7: clear beats a simultaneous write
    step(1'b0, 1'b0, 1'b1, 1'b1, 10'h155, 4'hB);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'h155, 4'h0);
    check("R7 pre-write", {dout_vld, dout}, 5'h1B);
    step(1'b0, 1'b0, 1'b1, 1'b0, 10'h2AA, 4'h4);
    idle();
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'h2AA, 4'h0);
    check("R7 no write on clear", {dout_vld, dout}, 5'h10);
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'h155, 4'h0);
    check("R7 prior data cleared", {dout_vld, dout}, 5'h10);

    // R9: reset drops the valid flag
    step(1'b0, 1'b1, 1'b0, 1'b1, 10'h155, 4'h0);
    rst_n = 1'b0;
    #1;
    check("R9 reset mid-read", {dout_vld, dout}, 5'h00);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule